// File: doc/BRIEF.md
# SIMD Lane Add/Subtract Unit with Greater-or-Equal Flags

This block adds or subtracts two 32-bit operands lane by lane. The operands are split into two 16-bit halfword lanes or four 8-bit byte lanes. A 4-bit operation code selects one of twelve signed or unsigned operations. Two of the halfword operations in each signedness exchange halfwords between the operands: one lane adds while the other subtracts. The unit returns the wrapped lane results and a 4-bit greater-or-equal flag vector, `ge`. A later lane-select step can use `ge`.

Each lane result is computed one bit wider than the lane. The flag of a lane comes from that full-precision value:
- A signed lane flags a non-negative result.
- An unsigned additive lane flags a carry out of the lane.
- An unsigned subtractive lane flags the absence of a borrow.

An output stage either passes the result straight through (`REG_OUT = 0`) or registers it (`REG_OUT = 1`). The registered stage is a two-state machine:
- `ST_EMPTY`: nothing is presented and `out_valid` is low.
- `ST_FULL`: a result captured on `in_valid` is presented and `out_valid` is high.

The stage changes state as follows:
- `EMPTY->FULL` and `FULL->FULL` take place on a cycle with `in_valid` high.
- `FULL->EMPTY` and `EMPTY->EMPTY` take place on a cycle with `in_valid` low.
- Synchronous reset forces `ST_EMPTY`.

Top module: `simd_lane_addsub`

## Requirements
- R1: The operation code `op_code` is decoded as follows. Bit 3 high selects unsigned lanes. Bits 2:0 select the operation:
  - 0: halfword add.
  - 1: halfword subtract.
  - 2: add-subtract exchange.
  - 3: subtract-add exchange.
  - 4: byte add.
  - 5: byte subtract.
  
  Each lane result is the low 16 or 8 bits of the exact result, so it wraps on overflow.
- R2: In halfword operations, `ge[3]` and `ge[2]` both give the flag of the upper lane (bits 31:16). `ge[1]` and `ge[0]` both give the flag of the lower lane (bits 15:0).
- R3: In byte operations, `ge[n]` is the flag of the byte at bits 8n+7:8n.
- R4: In a signed lane (`op_code[3]` = 0), the flag is 1 exactly when the exact sum or difference is at least zero. This holds even when the wrapped result overflows.
- R5: In an unsigned additive lane, the flag is 1 exactly when the exact sum is at least 2^16 (halfword) or 2^8 (byte).
- R6: In an unsigned subtractive lane, the flag is 1 exactly when the minuend is at least the subtrahend, that is, no borrow occurs.
- R7: Add-subtract exchange (codes 2 and 10) gives an upper lane of A[31:16] + B[15:0] and a lower lane of A[15:0] - B[31:16].
- R8: Subtract-add exchange (codes 3 and 11) gives an upper lane of A[31:16] - B[15:0] and a lower lane of A[15:0] + B[31:16].
- R9: Codes 6, 7, 14 and 15 produce a zero result and `ge` = 0000.
- R10: With `REG_OUT` = 1, the result and flags seen on a rising edge with `in_valid` high are presented after that edge, with `out_valid` high. After an edge with `in_valid` low, `out_valid` is low and the result and flags hold their previous values. With `REG_OUT` = 0, the outputs follow the inputs in the same cycle and `out_valid` equals `in_valid`.
- R11: With `REG_OUT` = 1, a rising edge with `rst` high clears the result, the flags and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered output stage |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op_code | input | 4 | Operation select (see R1) |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| out_valid | output | 1 | Result and flags are valid |
| res | output | 32 | Wrapped lane results |
| ge | output | 4 | Greater-or-equal flags per lane |

## Verification
The bench builds two copies of the block with the default 32-bit width: one with `REG_OUT` = 1 and one with `REG_OUT` = 0. It drives both from the same stimulus. The registered copy brings capture, hold, valid timing and reset clearing within reach. The pass-through copy confirms that the same lane arithmetic appears in the same cycle. Every one of the sixteen codes is run with random operands and with lanes built from 0x0000, 0x7FFF, 0x8000 and 0xFFFF. These lanes hit signed overflow, carry out and borrow at both lane widths.

// File: rtl/simd_pkg.sv
package simd_pkg;

    // Operation codes: bit 3 selects unsigned lanes.
    typedef enum logic [3:0] {
        OP_S_ADD_H = 4'h0,
        OP_S_SUB_H = 4'h1,
        OP_S_ASX   = 4'h2,
        OP_S_SAX   = 4'h3,
        OP_S_ADD_B = 4'h4,
        OP_S_SUB_B = 4'h5,
        OP_U_ADD_H = 4'h8,
        OP_U_SUB_H = 4'h9,
        OP_U_ASX   = 4'hA,
        OP_U_SAX   = 4'hB,
        OP_U_ADD_B = 4'hC,
        OP_U_SUB_B = 4'hD
    } simd_op_e;

    // Decoded lane controls.
    typedef struct packed {
        logic legal;
        logic uns;
        logic byte_mode;
        logic xchg;
        logic hi_sub;
        logic lo_sub;
    } simd_ctrl_t;

    // Registered output stage states.
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_st_e;

endpackage

// File: rtl/simd_op_decode.sv
module simd_op_decode
    import simd_pkg::*;
(
    input  logic [3:0] op_code,
    output simd_ctrl_t ctrl
);

    always_comb begin
        ctrl     = '0;
        ctrl.uns = op_code[3];
        unique case (op_code)
            OP_S_ADD_H, OP_U_ADD_H: begin
                ctrl.legal = 1'b1;
            end
            OP_S_SUB_H, OP_U_SUB_H: begin
                ctrl.legal  = 1'b1;
                ctrl.hi_sub = 1'b1;
                ctrl.lo_sub = 1'b1;
            end
            OP_S_ASX, OP_U_ASX: begin
                ctrl.legal  = 1'b1;
                ctrl.xchg   = 1'b1;
                ctrl.lo_sub = 1'b1;
            end
            OP_S_SAX, OP_U_SAX: begin
                ctrl.legal  = 1'b1;
                ctrl.xchg   = 1'b1;
                ctrl.hi_sub = 1'b1;
            end
            OP_S_ADD_B, OP_U_ADD_B: begin
                ctrl.legal     = 1'b1;
                ctrl.byte_mode = 1'b1;
            end
            OP_S_SUB_B, OP_U_SUB_B: begin
                ctrl.legal     = 1'b1;
                ctrl.byte_mode = 1'b1;
                ctrl.hi_sub    = 1'b1;
                ctrl.lo_sub    = 1'b1;
            end
            default: begin
                ctrl = '0;
            end
        endcase
    end

endmodule

// File: rtl/simd_lane.sv
module simd_lane #(
    parameter int LW = 8
) (
    input  logic          uns,
    input  logic          sub,
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    output logic [LW-1:0] res,
    output logic          ge
);

    logic [LW:0] ea;
    logic [LW:0] eb;
    logic [LW:0] full;

    // Zero-extend unsigned lanes, sign-extend signed lanes.
    always_comb begin
        ea = {(uns ? 1'b0 : a[LW-1]), a};
        eb = {(uns ? 1'b0 : b[LW-1]), b};
        if (sub) begin
            full = ea - eb;
        end else begin
            full = ea + eb;
        end
        res = full[LW-1:0];
        // Unsigned add: the top bit is the carry. Otherwise it is the sign or the borrow.
        if (uns && !sub) begin
            ge = full[LW];
        end else begin
            ge = ~full[LW];
        end
    end

endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
    import simd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  simd_ctrl_t        ctrl,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res,
    output logic [3:0]        ge
);

    localparam int N_BYTE = 4;
    localparam int N_HALF = 2;
    localparam int BW     = DATA_W / N_BYTE;
    localparam int HW     = DATA_W / N_HALF;

    logic [DATA_W-1:0] byte_res;
    logic [N_BYTE-1:0] byte_ge;
    logic [DATA_W-1:0] half_res;
    logic [N_HALF-1:0] half_ge;

    for (genvar i = 0; i < N_BYTE; i++) begin : g_byte
        simd_lane #(.LW(BW)) u_lane (
            .uns (ctrl.uns),
            .sub (ctrl.lo_sub),
            .a   (opa[i*BW +: BW]),
            .b   (opb[i*BW +: BW]),
            .res (byte_res[i*BW +: BW]),
            .ge  (byte_ge[i])
        );
    end

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        logic [HW-1:0] partner;
        logic          lane_sub;
        // Exchange variants take the opposite halfword of operand B.
        assign partner  = ctrl.xchg ? opb[(N_HALF-1-h)*HW +: HW] : opb[h*HW +: HW];
        assign lane_sub = (h == N_HALF - 1) ? ctrl.hi_sub : ctrl.lo_sub;
        simd_lane #(.LW(HW)) u_lane (
            .uns (ctrl.uns),
            .sub (lane_sub),
            .a   (opa[h*HW +: HW]),
            .b   (partner),
            .res (half_res[h*HW +: HW]),
            .ge  (half_ge[h])
        );
    end

    always_comb begin
        if (!ctrl.legal) begin
            res = '0;
            ge  = '0;
        end else if (ctrl.byte_mode) begin
            res = byte_res;
            ge  = byte_ge;
        end else begin
            res = half_res;
            ge  = {half_ge[1], half_ge[1], half_ge[0], half_ge[0]};
        end
    end

endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage
    import simd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int GE_W    = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_res,
    input  logic [GE_W-1:0]   in_ge,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_res,
    output logic [GE_W-1:0]   out_ge
);

    if (REG_OUT) begin : g_reg
        stage_st_e         st_q;
        stage_st_e         st_d;
        logic [DATA_W-1:0] res_q;
        logic [GE_W-1:0]   ge_q;

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                ST_EMPTY: st_d = in_valid ? ST_FULL : ST_EMPTY;
                ST_FULL:  st_d = in_valid ? ST_FULL : ST_EMPTY;
                default:  st_d = ST_EMPTY;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= ST_EMPTY;
            end else begin
                st_q <= st_d;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                res_q <= '0;
                ge_q  <= '0;
            end else if (in_valid) begin
                res_q <= in_res;
                ge_q  <= in_ge;
            end
        end

        always_comb begin
            out_valid = (st_q == ST_FULL);
            out_res   = res_q;
            out_ge    = ge_q;
        end
    end else begin : g_pass
        always_comb begin
            out_valid = in_valid;
            out_res   = in_res;
            out_ge    = in_ge;
        end
    end

endmodule

// File: rtl/simd_lane_addsub.sv
module simd_lane_addsub
    import simd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] res,
    output logic [3:0]        ge
);

    localparam int GE_W = 4;

    simd_ctrl_t        ctrl;
    logic [DATA_W-1:0] lane_res;
    logic [GE_W-1:0]   lane_ge;

    simd_op_decode u_dec (
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    simd_lane_array #(.DATA_W(DATA_W)) u_lanes (
        .ctrl (ctrl),
        .opa  (opa),
        .opb  (opb),
        .res  (lane_res),
        .ge   (lane_ge)
    );

    simd_out_stage #(
        .DATA_W  (DATA_W),
        .GE_W    (GE_W),
        .REG_OUT (REG_OUT)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_res    (lane_res),
        .in_ge     (lane_ge),
        .out_valid (out_valid),
        .out_res   (res),
        .out_ge    (ge)
    );

endmodule

// File: rtl/simd_lane_addsub_chk.sv
module simd_lane_addsub_chk
    import simd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [3:0]        op_code,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic              out_valid,
    input logic [DATA_W-1:0] res,
    input logic [3:0]        ge
);

    localparam int HW = DATA_W / 2;
    localparam int BW = DATA_W / 4;

    logic [3:0]        op_q;
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] b_q;
    logic [3:0]        c_op;
    logic [DATA_W-1:0] c_a;
    logic [DATA_W-1:0] c_b;
    logic signed [HW:0] s_lo;
    logic              c_half;
    logic              c_unused;

    // Inputs that belong to the result on the output pins.
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
            a_q  <= '0;
            b_q  <= '0;
        end else if (in_valid) begin
            op_q <= op_code;
            a_q  <= opa;
            b_q  <= opb;
        end
    end

    always_comb begin
        c_op     = REG_OUT ? op_q : op_code;
        c_a      = REG_OUT ? a_q : opa;
        c_b      = REG_OUT ? b_q : opb;
        s_lo     = $signed({c_a[HW-1], c_a[HW-1:0]}) + $signed({c_b[HW-1], c_b[HW-1:0]});
        c_half   = (c_op[2:0] < 3'd4);
        c_unused = (c_op[2:0] > 3'd5);
    end

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid && c_unused |-> (res == '0) && (ge == 4'b0000)); // R9

    AST_HALF_GE_PAIR: assert property (@(posedge clk) disable iff (rst)
        out_valid && c_half |-> (ge[3] == ge[2]) && (ge[1] == ge[0])); // R2

    AST_UADD_WRAP: assert property (@(posedge clk) disable iff (rst)
        out_valid && (c_op == OP_U_ADD_H) |-> res[DATA_W-1:HW] == HW'(c_a[DATA_W-1:HW] + c_b[DATA_W-1:HW])); // R1

    AST_SIGNED_GE: assert property (@(posedge clk) disable iff (rst)
        out_valid && (c_op == OP_S_ADD_H) |-> ge[0] == (s_lo >= 0)); // R4

    AST_CARRY_GE: assert property (@(posedge clk) disable iff (rst)
        out_valid && (c_op == OP_U_ADD_B) |-> ge[0] == (({1'b0, c_a[BW-1:0]} + {1'b0, c_b[BW-1:0]}) > {1'b0, {BW{1'b1}}})); // R5

    AST_BORROW_GE: assert property (@(posedge clk) disable iff (rst)
        out_valid && (c_op == OP_U_SUB_B) |-> ge[0] == (c_a[BW-1:0] >= c_b[BW-1:0])); // R6

    AST_ASX_LOW: assert property (@(posedge clk) disable iff (rst)
        out_valid && (c_op == OP_S_ASX) |-> res[HW-1:0] == HW'(c_a[HW-1:0] - c_b[DATA_W-1:HW])); // R7

    AST_SAX_HIGH: assert property (@(posedge clk) disable iff (rst)
        out_valid && (c_op == OP_U_SAX) |-> res[DATA_W-1:HW] == HW'(c_a[DATA_W-1:HW] - c_b[HW-1:0])); // R8

    AST_BYTE_GE_TOP: assert property (@(posedge clk) disable iff (rst)
        out_valid && (c_op == OP_U_SUB_B) |-> ge[3] == (c_a[DATA_W-1 -: BW] >= c_b[DATA_W-1 -: BW])); // R3

    if (REG_OUT) begin : g_reg_props
        AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid); // R10

        AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid && $stable(res) && $stable(ge)); // R10

        AST_RESET_CLEARS: assert property (@(posedge clk)
            rst |=> !out_valid && (res == '0) && (ge == 4'b0000)); // R11
    end else begin : g_pass_props
        AST_PASS_VALID: assert property (@(posedge clk) disable iff (rst)
            out_valid == in_valid); // R10
    end

endmodule

bind simd_lane_addsub simd_lane_addsub_chk #(
    .DATA_W  (DATA_W),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .res       (res),
    .ge        (ge)
);

// File: tb/simd_lane_addsub_tb_top.sv
module simd_lane_addsub_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 40;
    localparam int N_VEC      = 14;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] r;
        logic [3:0]  g;
    } vec_t;

    // Hand-computed vectors: code, A, B, expected result, expected flags.
    localparam vec_t VEC [N_VEC] = '{
        '{4'h0, 32'h7FFF_0001, 32'h0001_FFFF, 32'h8000_0000, 4'b1111},
        '{4'hC, 32'hFF80_0100, 32'h0180_FF00, 32'h0000_0000, 4'b1110},
        '{4'h9, 32'h0005_0003, 32'h0003_0005, 32'h0002_FFFE, 4'b1100},
        '{4'h2, 32'h0010_0020, 32'h0030_0040, 32'h0050_FFF0, 4'b1100},
        '{4'hB, 32'h0010_0020, 32'h0030_0040, 32'hFFD0_0050, 4'b0000},
        '{4'h5, 32'h807F_0001, 32'h01FF_0101, 32'h7F80_FF00, 4'b0101},
        '{4'h7, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 4'b0000},
        '{4'hA, 32'hFFFF_0000, 32'h0001_0001, 32'h0000_FFFF, 4'b1100},
        '{4'h1, 32'h8000_0000, 32'h0001_8000, 32'h7FFF_8000, 4'b0011},
        '{4'h4, 32'h7F80_FF01, 32'h0180_01FE, 32'h8000_00FF, 4'b1010},
        '{4'h3, 32'h0001_0002, 32'h0005_0003, 32'hFFFE_0007, 4'b0011},
        '{4'h8, 32'h8000_0001, 32'h8000_FFFE, 32'h0000_FFFF, 4'b1100},
        '{4'hD, 32'h1000_FF05, 32'h1001_FE06, 32'h00FF_01FF, 4'b1010},
        '{4'hE, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0000_0000, 4'b0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        out_valid;
    logic [31:0] res;
    logic [3:0]  ge;
    logic        out_valid_c;
    logic [31:0] res_c;
    logic [3:0]  ge_c;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    simd_lane_addsub #(.DATA_W(32), .REG_OUT(1'b1)) dut_i (
        .clk (clk), .rst (rst), .in_valid (in_valid), .op_code (op_code),
        .opa (opa), .opb (opb), .out_valid (out_valid), .res (res), .ge (ge)
    );

    simd_lane_addsub #(.DATA_W(32), .REG_OUT(1'b0)) dut_c_i (
        .clk (clk), .rst (rst), .in_valid (in_valid), .op_code (op_code),
        .opa (opa), .opb (opb), .out_valid (out_valid_c), .res (res_c), .ge (ge_c)
    );

    task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (valid,ge,res)", req, act, exp);
        end
    endtask

    // Requirement tag for an operation code.
    function automatic string tag_of(input logic [3:0] op);
        case (op[2:0])
            3'd0, 3'd1: return op[3] ? (op[0] ? "R1 R2 R6" : "R1 R2 R5") : "R1 R2 R4";
            3'd2:       return "R7 R2";
            3'd3:       return "R8 R2";
            3'd4, 3'd5: return op[3] ? "R3 R5 R6" : "R3 R4";
            default:    return "R9";
        endcase
    endfunction

    // Reference built from integer arithmetic.
    function automatic void ref_calc(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                                     output logic [31:0] r, output logic [3:0] g);
        int x;
        int y;
        int z;
        int kind;
        bit uns;
        bit sub;
        r    = '0;
        g    = '0;
        uns  = op[3];
        kind = int'(op[2:0]);
        if (kind > 5) return;
        if (kind >= 4) begin
            for (int i = 0; i < 4; i++) begin
                x = uns ? int'(a[8*i +: 8]) : int'($signed(a[8*i +: 8]));
                y = uns ? int'(b[8*i +: 8]) : int'($signed(b[8*i +: 8]));
                z = (kind == 4) ? x + y : x - y;
                r[8*i +: 8] = z[7:0];
                g[i] = (uns && kind == 4) ? (z >= 256) : (z >= 0);
            end
        end else begin
            for (int h = 0; h < 2; h++) begin
                logic [15:0] bp;
                bp = (kind >= 2) ? b[16*(1-h) +: 16] : b[16*h +: 16];
                case (kind)
                    0:       sub = 1'b0;
                    1:       sub = 1'b1;
                    2:       sub = (h == 0);
                    default: sub = (h == 1);
                endcase
                x = uns ? int'(a[16*h +: 16]) : int'($signed(a[16*h +: 16]));
                y = uns ? int'(bp) : int'($signed(bp));
                z = sub ? x - y : x + y;
                r[16*h +: 16] = z[15:0];
                g[2*h +: 2] = {2{(uns && !sub) ? (z >= 65536) : (z >= 0)}};
            end
        end
    endfunction

    // Drive one operation, check the pass-through copy in the same cycle
    // and the registered copy after the next edge.
    task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] er, input logic [3:0] eg);
        @(negedge clk);
        in_valid = 1'b1;
        op_code  = op;
        opa      = a;
        opb      = b;
        #1;
        check({tag_of(op), " R10 pass"}, {out_valid_c, ge_c, res_c}, {1'b1, eg, er});
        @(negedge clk);
        in_valid = 1'b0;
        check({tag_of(op), " R10 reg"}, {out_valid, ge, res}, {1'b1, eg, er});
    endtask

    function automatic logic [15:0] corner(input int sel);
        case (sel)
            0:       return 16'h0000;
            1:       return 16'h7FFF;
            2:       return 16'h8000;
            default: return 16'hFFFF;
        endcase
    endfunction

    initial begin
        logic [31:0] er;
        logic [3:0]  eg;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: state after reset
        check("R11 reset state", {out_valid, ge, res}, 37'h0);

        for (int v = 0; v < N_VEC; v++) begin
            run_op(VEC[v].op, VEC[v].a, VEC[v].b, VEC[v].r, VEC[v].g);
        end

        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < N_RAND; k++) begin
                logic [31:0] a;
                logic [31:0] b;
                if (k % 2 == 0) begin
                    a = $urandom;
                    b = $urandom;
                end else begin
                    a = {corner(int'($urandom_range(3))), corner(int'($urandom_range(3)))};
                    b = {corner(int'($urandom_range(3))), corner(int'($urandom_range(3)))};
                end
                ref_calc(4'(op), a, b, er, eg);
                run_op(4'(op), a, b, er, eg);
            end
        end

        // R10: hold after a cycle without in_valid
        run_op(4'h0, 32'h7FFF_0001, 32'h0001_FFFF, 32'h8000_0000, 4'b1111);
        op_code = 4'h9;
        opa     = 32'h0000_0000;
        opb     = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R10 hold", {out_valid, ge, res}, {1'b0, 4'b1111, 32'h8000_0000});
        #1;
        check("R10 pass valid low", {31'h0, out_valid_c}, 32'h0);

        // R11: reset in the middle of traffic
        run_op(4'h8, 32'h8000_0001, 32'h8000_FFFE, 32'h0000_FFFF, 4'b1100);
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b1;
        op_code  = 4'h0;
        opa      = 32'h1111_1111;
        opb      = 32'h2222_2222;
        @(negedge clk);
        check("R11 mid reset", {out_valid, ge, res}, 37'h0);
        rst      = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R11 after reset", {out_valid, ge, res}, 37'h0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R10 actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule